// File: doc/BRIEF.md
# Nibble-Mapped Dual Timer/Counter

This block holds a set of independent up-counters, two of 12 bits by default. A CPU with a 4-bit data path loads and reads each count one nibble at a time through a small address window. Each channel also has a control nibble in the same window. The control nibble starts or stops the channel and picks its count source: either a shared internal tick strobe from a clock prescaler outside the block, or the channel's own external count pin.

A running channel adds one on each rising edge of its selected count pulse. The external pin is synchronized by two flops before edge detection. Counting is aligned to the start command: a pulse that is already high when the channel starts does not count, and the first rising edge after the start does. When a count passes its maximum value it wraps to zero, keeps counting, and emits a one-cycle overflow pulse for an interrupt controller outside the block.

Top module: `nt_timer`

## Requirements
- R1: After synchronous reset every count nibble and every control nibble reads 0, and no overflow pulse is high.
- R2: Channel c occupies addresses 4c to 4c+3. Offset k (0, 1 or 2) reads and writes count bits 4k+3:4k. While the channel is stopped, a write to one count nibble changes only that nibble.
- R3: Offset 3 is the control nibble. Bit 0 is run (1 start, 0 stop) and bit 1 is the source (0 internal tick, 1 external pin). Bits 3:2 read as 0.
- R4: A running channel adds exactly one per rising edge of its selected pulse. A pulse held high counts only once.
- R5: A pulse that is already high when the start command is written does not count. The first rising edge after the start does.
- R6: With the internal source, a tick that rises just before a clock edge (after being low on the previous edge) is counted on that edge.
- R7: With the external source, the count changes on the third clock edge after the pin rises, and not before.
- R8: From FFF the count wraps to 000 and keeps counting. The overflow output is high for exactly the one cycle after the wrapping edge.
- R9: A stop command freezes the count in the cycle it is written. Edges seen while stopped are not counted, and the value is held for reading.
- R10: Writes to count nibbles of a running channel are ignored.
- R11: Channels are independent: writes to and counting on one channel never change another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Nibble address: channel in the upper bit, offset in the lower two |
| bus_we | input | 1 | Write strobe for the addressed nibble |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data of the addressed nibble (combinational) |
| tick_in | input | 1 | Internal count pulse from the prescaler, shared by all channels |
| pin_in | input | 2 | External count pins, one per channel, asynchronous |
| ovf_pulse | output | 2 | One-cycle overflow pulse per channel |

## Verification
The bench builds the block with its defaults: two channels of 12 bits. Two channels are enough to exercise the channel field of the address decode and to show that one channel's traffic leaves the other alone. Because the count is only 12 bits wide, loading a random value near FFF makes the wrap and the overflow pulse reachable within a few hundred pulses. Random trials therefore preload each channel, count a random number of ticks and compare the result, and the number of overflow pulses, with modular arithmetic. The external pin timing is covered by a directed case.

// File: rtl/nt_pkg.sv
package nt_pkg;

    localparam int NIB_W        = 4;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SRC_BIT = 1;

    typedef enum logic {
        SRC_TICK = 1'b0,
        SRC_PIN  = 1'b1
    } nt_src_e;

    typedef struct packed {
        nt_src_e src;
        logic    run;
    } nt_ctrl_t;

    function automatic nt_ctrl_t ctrl_from_nib(input logic [NIB_W-1:0] d);
        nt_ctrl_t c;
        c.run = d[CTRL_RUN_BIT];
        c.src = d[CTRL_SRC_BIT] ? SRC_PIN : SRC_TICK;
        return c;
    endfunction

    function automatic logic [NIB_W-1:0] ctrl_to_nib(input nt_ctrl_t c);
        logic [NIB_W-1:0] d;
        d = '0;
        d[CTRL_RUN_BIT] = c.run;
        d[CTRL_SRC_BIT] = (c.src == SRC_PIN);
        return d;
    endfunction

endpackage

// File: rtl/nt_edge.sv
module nt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic level;
    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign level = din;
        end else begin : g_sync
            logic [STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
            assign level = sync_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign rise = level & ~prev;
endmodule

// File: rtl/nt_channel.sv
module nt_channel
    import nt_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_rise,
    input  logic              pin_rise,
    input  logic              wr_cnt,
    input  logic              wr_ctrl,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [NIB_W-1:0]  wdata,
    output logic [CNT_W-1:0]  count,
    output nt_ctrl_t          ctrl,
    output logic              ovf
);
    localparam int NNIB = CNT_W / NIB_W;

    logic             sel_rise;
    logic             stop_now;
    logic             step;
    logic [CNT_W-1:0] loaded;

    assign sel_rise = (ctrl.src == SRC_PIN) ? pin_rise : tick_rise;
    assign stop_now = wr_ctrl && !wdata[CTRL_RUN_BIT];
    assign step     = ctrl.run && sel_rise && !stop_now;

    always_comb begin
        loaded = count;
        for (int k = 0; k < NNIB; k++) begin
            if (wr_cnt && (wr_slot == SLOT_W'(k)))
                loaded[k*NIB_W +: NIB_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ctrl  <= '{src: SRC_TICK, run: 1'b0};
            ovf   <= 1'b0;
        end else begin
            ovf <= step && (&count);
            if (wr_ctrl)
                ctrl <= ctrl_from_nib(wdata);
            if (step)
                count <= count + 1'b1;
            else if (!ctrl.run)
                count <= loaded;
        end
    end
endmodule

// File: rtl/nt_timer.sv
module nt_timer
    import nt_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int CNT_W = 12,
    parameter int SYNC  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [$clog2(N_CH)+$clog2(CNT_W/4+1)-1:0] bus_addr,
    input  logic                                   bus_we,
    input  logic [3:0]                             bus_wdata,
    output logic [3:0]                             bus_rdata,
    input  logic                                   tick_in,
    input  logic [N_CH-1:0]                        pin_in,
    output logic [N_CH-1:0]                        ovf_pulse
);
    localparam int NNIB   = CNT_W / NIB_W;
    localparam int SLOT_W = $clog2(NNIB + 1);
    localparam int CH_W   = $clog2(N_CH);
    localparam int AW     = CH_W + SLOT_W;

    logic              tick_rise;
    logic [SLOT_W-1:0] slot;
    logic [CH_W-1:0]   ch_sel;

    logic [N_CH-1:0][CNT_W-1:0] cnt_all;
    logic [N_CH-1:0]            run_all;
    nt_ctrl_t [N_CH-1:0]        ctrl_all;

    assign slot   = bus_addr[SLOT_W-1:0];
    assign ch_sel = bus_addr[AW-1:SLOT_W];

    nt_edge #(.STAGES(0)) u_tick_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (tick_in),
        .rise (tick_rise)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            logic pin_rise;
            logic hit;

            assign hit = bus_we && (ch_sel == CH_W'(c));

            nt_edge #(.STAGES(SYNC)) u_pin_edge (
                .clk  (clk),
                .rst  (rst),
                .din  (pin_in[c]),
                .rise (pin_rise)
            );

            nt_channel #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .tick_rise (tick_rise),
                .pin_rise  (pin_rise),
                .wr_cnt    (hit && (slot < SLOT_W'(NNIB))),
                .wr_ctrl   (hit && (slot == SLOT_W'(NNIB))),
                .wr_slot   (slot),
                .wdata     (bus_wdata),
                .count     (cnt_all[c]),
                .ctrl      (ctrl_all[c]),
                .ovf       (ovf_pulse[c])
            );

            assign run_all[c] = ctrl_all[c].run;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_sel == CH_W'(c)) begin
                if (slot == SLOT_W'(NNIB))
                    bus_rdata = ctrl_to_nib(ctrl_all[c]);
                for (int k = 0; k < NNIB; k++) begin
                    if (slot == SLOT_W'(k))
                        bus_rdata = cnt_all[c][k*NIB_W +: NIB_W];
                end
            end
        end
    end
endmodule

// File: rtl/nt_timer_chk.sv
module nt_timer_chk #(
    parameter int N_CH  = 2,
    parameter int CNT_W = 12,
    parameter int AW    = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic [AW-1:0]              bus_addr,
    input logic                       bus_we,
    input logic [3:0]                 bus_rdata,
    input logic [N_CH-1:0]            ovf_pulse,
    input logic [N_CH-1:0][CNT_W-1:0] cnt_all,
    input logic [N_CH-1:0]            run_all
);
    localparam int NNIB   = CNT_W / 4;
    localparam int SLOT_W = $clog2(NNIB + 1);
    localparam int CH_W   = AW - SLOT_W;

    // R3: the padding bits of a control nibble read as zero
    a_r3_ctrl_pad: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[SLOT_W-1:0] == SLOT_W'(NNIB)) |-> (bus_rdata[3:2] == 2'b00));

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            logic hit;
            assign hit = bus_we && (bus_addr[AW-1:SLOT_W] == CH_W'(c));

            // R1: a reset cycle leaves the count cleared and no pulse
            a_r1_reset_clear: assert property (@(posedge clk)
                $past(rst) |-> (cnt_all[c] == '0 && !ovf_pulse[c]));

            // R8: the overflow pulse lasts one cycle
            a_r8_ovf_single: assert property (@(posedge clk) disable iff (rst)
                ovf_pulse[c] |=> !ovf_pulse[c]);

            // R8: the overflow pulse comes with a count of zero
            a_r8_wrap_zero: assert property (@(posedge clk) disable iff (rst)
                ovf_pulse[c] |-> (cnt_all[c] == '0));

            // R9: a stopped, unwritten channel holds its count
            a_r9_hold: assert property (@(posedge clk) disable iff (rst)
                (!run_all[c] && !hit) |=> (cnt_all[c] == $past(cnt_all[c])));

            // R10: a running channel only holds or steps by one
            a_r10_step_only: assert property (@(posedge clk) disable iff (rst)
                run_all[c] |=> (cnt_all[c] == $past(cnt_all[c]) ||
                                cnt_all[c] == CNT_W'($past(cnt_all[c]) + 1'b1)));
        end
    endgenerate
endmodule

bind nt_timer nt_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .ovf_pulse (ovf_pulse),
    .cnt_all   (cnt_all),
    .run_all   (run_all)
);

// File: tb/nt_timer_test.sv
module nt_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       tick_in = 1'b0;
    logic [1:0] pin_in = '0;
    logic [1:0] ovf_pulse;

    int checks = 0;
    int errors = 0;
    int ovf_seen [2];
    bit done = 1'b0;

    always #5 clk = ~clk;

    nt_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .pin_in(pin_in), .ovf_pulse(ovf_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ovf_pulse[0]) ovf_seen[0]++;
            if (ovf_pulse[1]) ovf_seen[1]++;
        end
    end

    function automatic logic [2:0] adr(input int ch, input int off);
        return 3'(ch * 4 + off);
    endfunction

    function automatic logic [11:0] exp_count(input logic [11:0] init, input int n);
        return 12'((int'(init) + n) % 4096);
    endfunction

    function automatic int exp_wraps(input logic [11:0] init, input int n);
        return (int'(init) + n) / 4096;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(input int ch, output logic [11:0] v);
        logic [3:0] n0, n1, n2;
        rd(adr(ch, 0), n0);
        rd(adr(ch, 1), n1);
        rd(adr(ch, 2), n2);
        v = {n2, n1, n0};
    endtask

    task automatic load(input int ch, input logic [11:0] v);
        wr(adr(ch, 0), v[3:0]);
        wr(adr(ch, 1), v[7:4]);
        wr(adr(ch, 2), v[11:8]);
    endtask

    task automatic tick_pulse();
        @(negedge clk) tick_in = 1'b1;
        @(negedge clk) tick_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] v, v1;
        logic [3:0]  n;
        void'($urandom(32'h5EED_0047));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int ch = 0; ch < 2; ch++) begin
            rd_cnt(ch, v);
            chk("R1 count", v, 12'h000);
            rd(adr(ch, 3), n);
            chk("R1 ctrl", n, 4'h0);
        end
        chk("R1 ovf", ovf_pulse, 2'b00);

        // R2: a single nibble write changes only that nibble
        wr(adr(1, 1), 4'hA);
        rd_cnt(1, v);
        chk("R2 nibble1", v, 12'h0A0);
        load(1, 12'h5C3);
        rd_cnt(1, v);
        chk("R2 full load", v, 12'h5C3);

        // R3: control readback pads high bits with zero
        wr(adr(0, 3), 4'hE);
        rd(adr(0, 3), n);
        chk("R3 ctrl readback", n, 4'h2);
        wr(adr(0, 3), 4'h0);

        // R6 and R4: internal tick latency, held level counts once
        load(0, 12'h010);
        wr(adr(0, 3), 4'h1);
        @(negedge clk) begin tick_in = 1'b1; bus_addr = adr(0, 0); end
        @(negedge clk);
        chk("R6 tick counted on first edge", bus_rdata, 4'h1);
        repeat (4) @(negedge clk);
        chk("R4 held level counts once", bus_rdata, 4'h1);
        tick_in = 1'b0;

        // R5: tick already high at start does not count
        wr(adr(0, 3), 4'h0);
        load(0, 12'h100);
        @(negedge clk) tick_in = 1'b1;
        wr(adr(0, 3), 4'h1);
        repeat (3) @(negedge clk);
        rd_cnt(0, v);
        chk("R5 high at start ignored", v, 12'h100);
        tick_in = 1'b0;
        tick_pulse();
        rd_cnt(0, v);
        chk("R5 first rise after start", v, 12'h101);

        // R10: write to a running channel is ignored
        wr(adr(0, 0), 4'h9);
        rd_cnt(0, v);
        chk("R10 write while running", v, 12'h101);

        // R9: stop freezes, later ticks ignored
        wr(adr(0, 3), 4'h0);
        repeat (3) tick_pulse();
        rd_cnt(0, v);
        chk("R9 frozen after stop", v, 12'h101);

        // R8: wrap from FFF
        load(0, 12'hFFF);
        ovf_seen[0] = 0;
        wr(adr(0, 3), 4'h1);
        @(negedge clk) begin tick_in = 1'b1; bus_addr = adr(0, 2); end
        @(negedge clk);
        chk("R8 ovf high after wrap", ovf_pulse[0], 1'b1);
        chk("R8 count wrapped", bus_rdata, 4'h0);
        tick_in = 1'b0;
        @(negedge clk);
        chk("R8 ovf one cycle", ovf_pulse[0], 1'b0);
        tick_pulse();
        wr(adr(0, 3), 4'h0);
        rd_cnt(0, v);
        chk("R8 counts on after wrap", v, 12'h001);
        chk("R8 single pulse", ovf_seen[0], 1);

        // R7: external pin path, channel 1
        load(1, 12'h0F0);
        wr(adr(1, 3), 4'h3);
        @(negedge clk) begin pin_in[1] = 1'b1; bus_addr = adr(1, 0); end
        @(negedge clk);
        @(negedge clk);
        chk("R7 no count after two edges", bus_rdata, 4'h0);
        @(negedge clk);
        chk("R7 count on third edge", bus_rdata, 4'h1);
        pin_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        tick_pulse();
        rd_cnt(1, v);
        chk("R7 pin source ignores tick", v, 12'h0F1);
        wr(adr(1, 3), 4'h0);

        // Random trials: preload, count ticks, compare (R4, R8, R11)
        for (int t = 0; t < 24; t++) begin
            int ch, other, npl;
            logic [11:0] init, oth_before;
            ch    = t % 2;
            other = 1 - ch;
            init  = ($urandom_range(0, 1) == 1) ? 12'(4095 - $urandom_range(0, 40))
                                                 : 12'($urandom_range(0, 4095));
            npl   = $urandom_range(1, 120);
            rd_cnt(other, oth_before);
            load(ch, init);
            ovf_seen[ch] = 0;
            wr(adr(ch, 3), 4'h1);
            for (int p = 0; p < npl; p++) begin
                tick_pulse();
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
            wr(adr(ch, 3), 4'h0);
            rd_cnt(ch, v);
            chk("R4 random count", v, exp_count(init, npl));
            chk("R8 random wraps", ovf_seen[ch], exp_wraps(init, npl));
            rd_cnt(other, v1);
            chk("R11 other channel untouched", v1, oth_before);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule